// File: doc/BRIEF.md
# Inbound Request Header Error Checker

This block inspects the header of every inbound request packet on a serial RapidIO endpoint and decides, one clock later, whether the packet is forwarded or dropped. It checks four things: whether the format type is one the endpoint serves, whether the transport-size field is legal and enabled, whether the destination ID belongs to this endpoint, and what an external address decoder reports about window hits. Which of these checks apply depends on the passthrough, accept-all and alternate-ID settings.

Every detected error has the same effect. The packet is dropped, no error response is generated, and a sticky detect bit for that error class is set. An interrupt line is asserted while any detect bit is set whose enable is also set. On the first error after all detect bits are clear, the address, extended address, IDs, format type and capture type field of the failing header are latched. The packet's transport size picks the bit positions they are taken from. The capture stays frozen until software has cleared every detect bit by writing ones to them.

Top module: `inb_hdr_checker`

## Requirements
- R1: `decValid` is high in the cycle after each cycle in which `hdrValid` is high, and low otherwise. A new header can be accepted every cycle.
- R2: Format types 2, 5, 6, 8, 10, 11 and 13 (header bits 12–15, bit 0 = MSB of `hdrWord`) are supported. Any other value sets detect bit 0 only when the packet is not passthrough. A packet is not passthrough when `passEn`=0, or `acceptAll`=1, or its destination ID matches this endpoint as defined in R5.
- R3: The transport-size field sits at header bits 10–11, with 00 = small and 01 = large. The values 10 and 11 are reserved and always set detect bit 1. A reserved value is otherwise handled with the small layout.
- R4: A small or large packet whose size is not enabled in `ttEnable` (bit 0 small, bit 1 large) sets detect bit 1 when `acceptAll`=1 or `passEn`=0.
- R5: A destination ID matches when it equals `deviceId`, or when `altIdEn`=1 and it equals `altDeviceId`. Small packets compare the low 8 bits and large packets compare 16 bits. With `passEn`=0 and `acceptAll`=0, a mismatch sets detect bit 2.
- R6: A format-6 packet with `winOverlap` high sets detect bit 3. It is then also checked as a non-format-6 packet.
- R7: A supported-format packet with `winProtected` high sets detect bit 4.
- R8: `decDrop` is high with `decValid` if and only if at least one error was found in that header. Detect bits stay set until `clrValid` is high with a 1 in the matching `clrMask` bit.
- R9: `irq` is high exactly when some detect bit and its `errEnable` bit are both 1.
- R10: For a small packet, the capture is loaded from header bits as follows: extended address 78–79, address 48–76, destination 16–23 with the upper byte zero, source 24–31 with the upper byte zero, type 12–15, capture type field 32–35.
- R11: For a large packet, the capture is loaded as follows: extended address 94–95, address 64–92, destination 16–31, source 32–47, type 12–15, capture type field 48–51.
- R12: A capture is taken only for an erroring header that arrives while all detect bits are zero. A packet with several errors sets all of their bits but yields one capture. The capture then holds until every detect bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header word valid strobe |
| hdrWord | input | 96 | Header, packet bit 0 in bit 95 |
| winOverlap | input | 1 | Decoder: request hits overlapping windows |
| winProtected | input | 1 | Decoder: protected or local config window hit |
| deviceId | input | 16 | Endpoint device ID |
| altDeviceId | input | 16 | Alternate device ID |
| altIdEn | input | 1 | Alternate ID enable |
| passEn | input | 1 | Passthrough mode |
| acceptAll | input | 1 | Accept-all mode |
| ttEnable | input | 2 | Enabled transport sizes (bit0 small, bit1 large) |
| errEnable | input | 5 | Per-error interrupt enables |
| clrValid | input | 1 | Detect clear strobe |
| clrMask | input | 5 | Write-one-to-clear mask |
| decValid | output | 1 | Decision valid |
| decDrop | output | 1 | 1 = drop, 0 = forward |
| errDetect | output | 5 | Sticky detect bits |
| irq | output | 1 | Interrupt |
| capXAddr | output | 2 | Captured extended address |
| capAddr | output | 29 | Captured address |
| capDestId | output | 16 | Captured destination ID |
| capSrcId | output | 16 | Captured source ID |
| capFtype | output | 4 | Captured format type |
| capTtype | output | 4 | Captured capture-type field |

## Verification
The hardest states to reach from the ports are those where one mode setting turns a check on or off. Examples are a passthrough packet with an unsupported type that must still be flagged because it is addressed here, or a disabled large size that is tolerated under passthrough but flagged under accept-all. A table walks each such combination, clearing the detect bits before every row so that the bits of each row can be read alone. Directed sequences then fill the capture with one layout and confirm that a later packet with different field values leaves it untouched. They also confirm that a partial clear keeps the lock, and that a full clear lets the other layout load.

// File: rtl/inb_hdr_pkg.sv
package inb_hdr_pkg;
  localparam int HDR_W = 96;
  localparam int ERR_N = 5;
  localparam int FT_W = 4;
  localparam int TT_W = 2;

  typedef enum logic [TT_W-1:0] {
    TT_SMALL = 2'b00,
    TT_LARGE = 2'b01,
    TT_RSV0  = 2'b10,
    TT_RSV1  = 2'b11
  } ttSize_e;

  // Bit index of each error class in the detect vector
  localparam int E_UNSUP  = 0;
  localparam int E_TSIZE  = 1;
  localparam int E_DEST   = 2;
  localparam int E_BOUND  = 3;
  localparam int E_DECODE = 4;

  typedef struct packed {
    logic loadCap;
    logic isLarge;
  } ctrlStrobe_t;
endpackage

// File: rtl/inb_hdr_datapath.sv
module inb_hdr_datapath
  import inb_hdr_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int ADDR_W = 29
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HDR_W-1:0]   hdrWord,
  input  ctrlStrobe_t        strobe,
  output logic [FT_W-1:0]    fldFtype,
  output logic [TT_W-1:0]    fldTsize,
  output logic [ID_W-1:0]    fldDestId,
  output logic [1:0]         capXAddr,
  output logic [ADDR_W-1:0]  capAddr,
  output logic [ID_W-1:0]    capDestId,
  output logic [ID_W-1:0]    capSrcId,
  output logic [FT_W-1:0]    capFtype,
  output logic [3:0]         capTtype
);
  localparam int BYTE_W = ID_W / 2;
  // hdrWord index of packet bit k (big-endian numbering)
  localparam int TOP = HDR_W - 1;
  localparam int P_TSIZE = TOP - 10;
  localparam int P_FTYPE = TOP - 12;
  localparam int P_ID    = TOP - 16;
  localparam int P_S_SRC = TOP - 24;
  localparam int P_S_TT  = TOP - 32;
  localparam int P_S_A   = TOP - 48;
  localparam int P_S_XA  = TOP - 78;
  localparam int P_L_SRC = TOP - 32;
  localparam int P_L_TT  = TOP - 48;
  localparam int P_L_A   = TOP - 64;
  localparam int P_L_XA  = TOP - 94;

  logic [ID_W-1:0]   smallDest, smallSrc, largeDest, largeSrc;
  logic [ADDR_W-1:0] smallAddr, largeAddr;
  logic [1:0]        smallXa, largeXa;
  logic [3:0]        smallTt, largeTt;

  assign fldFtype = hdrWord[P_FTYPE -: FT_W];
  assign fldTsize = hdrWord[P_TSIZE -: TT_W];

  assign smallDest = {{BYTE_W{1'b0}}, hdrWord[P_ID -: BYTE_W]};
  assign smallSrc  = {{BYTE_W{1'b0}}, hdrWord[P_S_SRC -: BYTE_W]};
  assign smallTt   = hdrWord[P_S_TT -: 4];
  assign smallAddr = hdrWord[P_S_A -: ADDR_W];
  assign smallXa   = hdrWord[P_S_XA -: 2];

  assign largeDest = hdrWord[P_ID -: ID_W];
  assign largeSrc  = hdrWord[P_L_SRC -: ID_W];
  assign largeTt   = hdrWord[P_L_TT -: 4];
  assign largeAddr = hdrWord[P_L_A -: ADDR_W];
  assign largeXa   = hdrWord[P_L_XA -: 2];

  assign fldDestId = (fldTsize == TT_LARGE) ? largeDest : smallDest;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capXAddr  <= '0;
      capAddr   <= '0;
      capDestId <= '0;
      capSrcId  <= '0;
      capFtype  <= '0;
      capTtype  <= '0;
    end else if (strobe.loadCap) begin
      capFtype <= fldFtype;
      if (strobe.isLarge) begin
        capXAddr  <= largeXa;
        capAddr   <= largeAddr;
        capDestId <= largeDest;
        capSrcId  <= largeSrc;
        capTtype  <= largeTt;
      end else begin
        capXAddr  <= smallXa;
        capAddr   <= smallAddr;
        capDestId <= smallDest;
        capSrcId  <= smallSrc;
        capTtype  <= smallTt;
      end
    end
  end
endmodule

// File: rtl/inb_hdr_ctrl.sv
module inb_hdr_ctrl
  import inb_hdr_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic [FT_W-1:0]   fldFtype,
  input  logic [TT_W-1:0]   fldTsize,
  input  logic [ID_W-1:0]   fldDestId,
  input  logic [ID_W-1:0]   deviceId,
  input  logic [ID_W-1:0]   altDeviceId,
  input  logic              altIdEn,
  input  logic              passEn,
  input  logic              acceptAll,
  input  logic [1:0]        ttEnable,
  input  logic              winOverlap,
  input  logic              winProtected,
  input  logic [ERR_N-1:0]  errEnable,
  input  logic              clrValid,
  input  logic [ERR_N-1:0]  clrMask,
  output ctrlStrobe_t       strobe,
  output logic              decValid,
  output logic              decDrop,
  output logic [ERR_N-1:0]  errDetect,
  output logic              irq
);
  localparam int SMALL_ID_W = ID_W / 2;

  logic             isLarge, isReserved, ftypeOk, isSwrite;
  logic             hitPrimary, hitAlt, addressedHere, notPassthru;
  logic             sizeEnabled, dstCheckOn, sizeCheckOn;
  logic [ERR_N-1:0] errNow, clrEff, detectQ;

  always_comb begin
    unique case (fldFtype)
      4'd2, 4'd5, 4'd6, 4'd8, 4'd10, 4'd11, 4'd13: ftypeOk = 1'b1;
      default:                                    ftypeOk = 1'b0;
    endcase
  end

  assign isLarge    = (fldTsize == TT_LARGE);
  assign isReserved = fldTsize[1];
  assign isSwrite   = (fldFtype == 4'd6);

  // Small headers carry one byte of ID; large headers carry two.
  assign hitPrimary = isLarge ? (fldDestId == deviceId)
                              : (fldDestId[SMALL_ID_W-1:0] == deviceId[SMALL_ID_W-1:0]);
  assign hitAlt     = altIdEn && (isLarge ? (fldDestId == altDeviceId)
                              : (fldDestId[SMALL_ID_W-1:0] == altDeviceId[SMALL_ID_W-1:0]));
  assign addressedHere = hitPrimary || hitAlt;

  assign notPassthru = !passEn || acceptAll || addressedHere;
  assign dstCheckOn  = !passEn && !acceptAll;
  assign sizeCheckOn = acceptAll || !passEn;
  assign sizeEnabled = ttEnable[fldTsize[0]];

  always_comb begin
    errNow = '0;
    errNow[E_UNSUP]  = !ftypeOk && notPassthru;
    errNow[E_TSIZE]  = isReserved || (sizeCheckOn && !sizeEnabled);
    errNow[E_DEST]   = dstCheckOn && !addressedHere;
    errNow[E_BOUND]  = isSwrite && winOverlap;
    // Boundary-error packets fall through to the generic window check.
    errNow[E_DECODE] = ftypeOk && winProtected;
  end

  assign clrEff = clrValid ? clrMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decDrop  <= 1'b0;
      detectQ  <= '0;
    end else begin
      decValid <= hdrValid;
      decDrop  <= hdrValid && (errNow != '0);
      detectQ  <= (detectQ & ~clrEff) | (hdrValid ? errNow : '0);
    end
  end

  always_comb begin
    strobe.loadCap = hdrValid && (errNow != '0) && (detectQ == '0);
    strobe.isLarge = isLarge;
  end

  assign errDetect = detectQ;
  assign irq       = |(detectQ & errEnable);
endmodule

// File: rtl/inb_hdr_checker.sv
module inb_hdr_checker
  import inb_hdr_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int ADDR_W = 29
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hdrValid,
  input  logic [HDR_W-1:0]   hdrWord,
  input  logic               winOverlap,
  input  logic               winProtected,
  input  logic [ID_W-1:0]    deviceId,
  input  logic [ID_W-1:0]    altDeviceId,
  input  logic               altIdEn,
  input  logic               passEn,
  input  logic               acceptAll,
  input  logic [1:0]         ttEnable,
  input  logic [ERR_N-1:0]   errEnable,
  input  logic               clrValid,
  input  logic [ERR_N-1:0]   clrMask,
  output logic               decValid,
  output logic               decDrop,
  output logic [ERR_N-1:0]   errDetect,
  output logic               irq,
  output logic [1:0]         capXAddr,
  output logic [ADDR_W-1:0]  capAddr,
  output logic [ID_W-1:0]    capDestId,
  output logic [ID_W-1:0]    capSrcId,
  output logic [FT_W-1:0]    capFtype,
  output logic [3:0]         capTtype
);
  ctrlStrobe_t       strobe;
  logic [FT_W-1:0]   fldFtype;
  logic [TT_W-1:0]   fldTsize;
  logic [ID_W-1:0]   fldDestId;

  inb_hdr_datapath #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .hdrWord(hdrWord), .strobe(strobe),
    .fldFtype(fldFtype), .fldTsize(fldTsize), .fldDestId(fldDestId),
    .capXAddr(capXAddr), .capAddr(capAddr), .capDestId(capDestId),
    .capSrcId(capSrcId), .capFtype(capFtype), .capTtype(capTtype)
  );

  inb_hdr_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid),
    .fldFtype(fldFtype), .fldTsize(fldTsize), .fldDestId(fldDestId),
    .deviceId(deviceId), .altDeviceId(altDeviceId), .altIdEn(altIdEn),
    .passEn(passEn), .acceptAll(acceptAll), .ttEnable(ttEnable),
    .winOverlap(winOverlap), .winProtected(winProtected),
    .errEnable(errEnable), .clrValid(clrValid), .clrMask(clrMask),
    .strobe(strobe), .decValid(decValid), .decDrop(decDrop),
    .errDetect(errDetect), .irq(irq)
  );
endmodule

// File: rtl/inb_hdr_checker_sva.sv
module inb_hdr_checker_sva
  import inb_hdr_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int ADDR_W = 29
) (
  input logic               clk,
  input logic               rstN,
  input logic               hdrValid,
  input logic [HDR_W-1:0]   hdrWord,
  input logic               winOverlap,
  input logic [ID_W-1:0]    deviceId,
  input logic               altIdEn,
  input logic               passEn,
  input logic               acceptAll,
  input logic               clrValid,
  input logic               decValid,
  input logic               decDrop,
  input logic [ERR_N-1:0]   errDetect,
  input logic [ADDR_W-1:0]  capAddr,
  input logic [ID_W-1:0]    capDestId,
  input logic [ID_W-1:0]    capSrcId,
  input logic [FT_W-1:0]    capFtype
);
  localparam int TOP = HDR_W - 1;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> decValid);
  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !decValid);
  assert_drop_sets_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decDrop) |-> (errDetect != '0));
  assert_detect_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((errDetect != '0) && !clrValid) |=> (errDetect != '0));
  assert_capture_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((errDetect != '0) && !clrValid) |=>
      ($stable(capAddr) && $stable(capDestId) && $stable(capSrcId) && $stable(capFtype)));
  assert_large_dest_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !passEn && !acceptAll && !altIdEn &&
     hdrWord[TOP-10 -: 2] == 2'b01 && hdrWord[TOP-16 -: 16] != deviceId) |=> errDetect[2]);
  assert_swrite_overlap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrWord[TOP-12 -: 4] == 4'd6 && winOverlap) |=> errDetect[3]);
endmodule

bind inb_hdr_checker inb_hdr_checker_sva #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrWord(hdrWord),
  .winOverlap(winOverlap), .deviceId(deviceId), .altIdEn(altIdEn),
  .passEn(passEn), .acceptAll(acceptAll), .clrValid(clrValid),
  .decValid(decValid), .decDrop(decDrop), .errDetect(errDetect),
  .capAddr(capAddr), .capDestId(capDestId), .capSrcId(capSrcId),
  .capFtype(capFtype)
);

// File: tb/inb_hdr_checker_bench.sv
module inb_hdr_checker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hdrValid = 1'b0;
  logic [95:0] hdrWord = '0;
  logic        winOverlap = 1'b0, winProtected = 1'b0;
  logic [15:0] deviceId = 16'h0012, altDeviceId = 16'h0034;
  logic        altIdEn = 1'b0, passEn = 1'b0, acceptAll = 1'b0;
  logic [1:0]  ttEnable = 2'b11;
  logic [4:0]  errEnable = '0;
  logic        clrValid = 1'b0;
  logic [4:0]  clrMask = '0;
  logic        decValid, decDrop, irq;
  logic [4:0]  errDetect;
  logic [1:0]  capXAddr;
  logic [28:0] capAddr;
  logic [15:0] capDestId, capSrcId;
  logic [3:0]  capFtype, capTtype;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inb_hdr_checker u_inb_hdr_checker (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrWord(hdrWord),
    .winOverlap(winOverlap), .winProtected(winProtected),
    .deviceId(deviceId), .altDeviceId(altDeviceId), .altIdEn(altIdEn),
    .passEn(passEn), .acceptAll(acceptAll), .ttEnable(ttEnable),
    .errEnable(errEnable), .clrValid(clrValid), .clrMask(clrMask),
    .decValid(decValid), .decDrop(decDrop), .errDetect(errDetect), .irq(irq),
    .capXAddr(capXAddr), .capAddr(capAddr), .capDestId(capDestId),
    .capSrcId(capSrcId), .capFtype(capFtype), .capTtype(capTtype)
  );

  typedef struct packed {
    logic [3:0]  ft;
    logic [1:0]  tt;
    logic [15:0] dest;
    logic        pass, acc, alt, ovl, prot;
    logic [1:0]  ttEn;
    logic [4:0]  exp;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 io read
    '{4'd5,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 io write
    '{4'd6,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 swrite
    '{4'd8,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 maint
    '{4'd10, 2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 doorbell
    '{4'd11, 2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 message
    '{4'd13, 2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 response
    '{4'd3,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h01}, // R2 unsupported
    '{4'd3,  2'd0, 16'h0055, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R2 passthrough
    '{4'd3,  2'd0, 16'h0055, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'b11, 5'h01}, // R2 accept-all
    '{4'd3,  2'd0, 16'h0012, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h01}, // R2 addressed here
    '{4'd5,  2'd2, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h02}, // R3 reserved
    '{4'd5,  2'd3, 16'h0012, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h02}, // R3 reserved pass
    '{4'd5,  2'd1, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01, 5'h02}, // R4 large off
    '{4'd5,  2'd1, 16'h0012, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'b01, 5'h00}, // R4 pass skips
    '{4'd5,  2'd1, 16'h0012, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'b01, 5'h02}, // R4 accept-all
    '{4'd5,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b10, 5'h02}, // R4 small off
    '{4'd5,  2'd0, 16'h0034, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h04}, // R5 alt disabled
    '{4'd5,  2'd0, 16'h0034, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'b11, 5'h00}, // R5 alt small
    '{4'd5,  2'd1, 16'h0034, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'b11, 5'h00}, // R5 alt large
    '{4'd5,  2'd1, 16'h1234, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'b11, 5'h04}, // R5 large miss
    '{4'd5,  2'd1, 16'hFF12, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h04}, // R5 upper byte
    '{4'd5,  2'd0, 16'h0099, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h00}, // R5 pass skips
    '{4'd6,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b1,1'b0, 2'b11, 5'h08}, // R6 overlap
    '{4'd6,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'b11, 5'h18}, // R6 R7 both
    '{4'd5,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b1,1'b0, 2'b11, 5'h00}, // R6 not swrite
    '{4'd5,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b11, 5'h10}, // R7 protected
    '{4'd3,  2'd0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'b11, 5'h01}, // R7 not for UT
    '{4'd7,  2'd0, 16'h0099, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b11, 5'h05}, // R12 multi
    '{4'd4,  2'd1, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01, 5'h03}  // R4 multi
  };

  function automatic logic [95:0] mkHdr(input logic [3:0] ft, input logic [1:0] tt,
      input logic [15:0] dst, input logic [15:0] src, input logic [3:0] tc,
      input logic [28:0] a, input logic [1:0] xa);
    logic [95:0] h;
    h = '0;
    h[95-10 -: 2] = tt;
    h[95-12 -: 4] = ft;
    if (tt == 2'b01) begin
      h[95-16 -: 16] = dst;
      h[95-32 -: 16] = src;
      h[95-48 -: 4]  = tc;
      h[95-64 -: 29] = a;
      h[95-94 -: 2]  = xa;
    end else begin
      h[95-16 -: 8]  = dst[7:0];
      h[95-24 -: 8]  = src[7:0];
      h[95-32 -: 4]  = tc;
      h[95-48 -: 29] = a;
      h[95-78 -: 2]  = xa;
    end
    return h;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    clrValid = 1'b1; clrMask = 5'h1F;
    @(negedge clk);
    clrValid = 1'b0; clrMask = '0;
  endtask

  task automatic sendHdr(input logic [95:0] h);
    hdrValid = 1'b1; hdrWord = h;
    @(negedge clk);
    hdrValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 R8 R9 reset state
    check("R1 reset decValid", decValid, 0);
    check("R8 reset detect", errDetect, 0);
    check("R9 reset irq", irq, 0);
    check("R12 reset capture", capAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      passEn = VEC[i].pass; acceptAll = VEC[i].acc; altIdEn = VEC[i].alt;
      winOverlap = VEC[i].ovl; winProtected = VEC[i].prot; ttEnable = VEC[i].ttEn;
      sendHdr(mkHdr(VEC[i].ft, VEC[i].tt, VEC[i].dest, 16'h0, 4'h0, '0, 2'b00));
      check($sformatf("R1 row %0d valid", i), decValid, 1);
      check($sformatf("R8 row %0d drop", i), decDrop, (VEC[i].exp != 0));
      check($sformatf("R2-R7 row %0d bits", i), errDetect, VEC[i].exp);
      clearAll();
    end
    passEn = 0; acceptAll = 0; altIdEn = 0; winOverlap = 0; winProtected = 0;
    ttEnable = 2'b11;

    // R10 small capture, R9 irq gating
    sendHdr(mkHdr(4'd3, 2'b00, 16'h0012, 16'h00AB, 4'h9, 29'h1234567, 2'b10));
    check("R10 cap dest", capDestId, 16'h0012);
    check("R10 cap src", capSrcId, 16'h00AB);
    check("R10 cap ftype", capFtype, 4'd3);
    check("R10 cap ttype", capTtype, 4'h9);
    check("R10 cap addr", capAddr, 29'h1234567);
    check("R10 cap xaddr", capXAddr, 2'b10);
    check("R9 irq masked", irq, 0);
    errEnable = 5'b00010;
    #1 check("R9 irq other enable", irq, 0);
    errEnable = 5'b00001;
    #1 check("R9 irq enabled", irq, 1);

    // R12 lock: second error packet does not capture
    sendHdr(mkHdr(4'd7, 2'b00, 16'h0066, 16'h00CD, 4'h4, 29'h0000FFF, 2'b01));
    check("R12 locked dest", capDestId, 16'h0012);
    check("R12 locked addr", capAddr, 29'h1234567);
    check("R12 bits accumulate", errDetect, 5'h05);
    // partial clear keeps lock
    clrValid = 1'b1; clrMask = 5'h01;
    @(negedge clk);
    clrValid = 1'b0; clrMask = '0;
    check("R8 partial clear", errDetect, 5'h04);
    check("R9 irq after clear", irq, 0);
    sendHdr(mkHdr(4'd3, 2'b00, 16'h0012, 16'h0077, 4'h1, 29'h0000001, 2'b11));
    check("R12 still locked", capSrcId, 16'h00AB);
    clearAll();
    check("R8 full clear", errDetect, 0);

    // R11 large capture after unlock
    sendHdr(mkHdr(4'd3, 2'b01, 16'h0012, 16'hCDEF, 4'h5, 29'h0ABCDEF1, 2'b01));
    check("R11 cap dest", capDestId, 16'h0012);
    check("R11 cap src", capSrcId, 16'hCDEF);
    check("R11 cap ttype", capTtype, 4'h5);
    check("R11 cap addr", capAddr, 29'h0ABCDEF1);
    check("R11 cap xaddr", capXAddr, 2'b01);
    clearAll();

    // R1 back-to-back headers
    hdrValid = 1'b1; hdrWord = mkHdr(4'd2, 2'b00, 16'h0012, 0, 0, 0, 0);
    @(negedge clk);
    check("R1 b2b first valid", decValid, 1);
    check("R1 b2b first fwd", decDrop, 0);
    hdrWord = mkHdr(4'd9, 2'b00, 16'h0012, 0, 0, 0, 0);
    @(negedge clk);
    hdrValid = 1'b0;
    check("R1 b2b second valid", decValid, 1);
    check("R1 b2b second drop", decDrop, 1);
    @(negedge clk);
    check("R1 idle no valid", decValid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule